// File: doc/BRIEF.md
# Programmable Clock Output with Suspend Fallback

This block drives a clock output pin from a fast reference clock. The reference is divided by N+1, where N is a 4-bit factor taken from a configuration register. Software may rewrite N at any time. The new ratio is picked up only at a period boundary, so the output never shows a shortened pulse.

While the chip is suspended, the output can fall back to a slow low-power clock. A suspend request is first synchronised into the reference domain. It then has to stay asserted for a programmable number of reference cycles before the output is handed to the slow clock. A configuration flag, `keep_fast`, disables this fallback entirely. When suspend ends, or `keep_fast` is set, the output returns to the divided clock.

In both directions the handover goes through a break-before-make multiplexer. Each clock's enable changes only while that clock is low, and one source is released before the other is admitted.

The suspend sequencing is a three-state machine:

| State | Role |
|-------|------|
| `ST_RUN` | The divided clock is selected. |
| `ST_ARMED` | Suspend has been seen and the delay is being counted. |
| `ST_LAZY` | The slow clock is selected. |

Its transitions are:

| Transition | From → To | Condition |
|------------|-----------|-----------|
| arm | `ST_RUN` → `ST_ARMED` | Synchronised suspend is high and `keep_fast` is low. |
| abort | `ST_ARMED` → `ST_RUN` | Suspend drops or `keep_fast` is set before the delay ends. |
| expire | `ST_ARMED` → `ST_LAZY` | The delay count reaches `DELAY_CYC`. |
| wake | `ST_LAZY` → `ST_RUN` | Suspend drops or `keep_fast` is set. |

Top module: `clkout_gen`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low. After reset the divided clock is the selected source. The divider's first period starts on the first reference edge after release, with the high phase first.
- R2: For N from 1 to 15, each output period lasts N+1 reference cycles. It starts with a high phase of floor((N+1)/2) cycles, and the rest of the period is low. So N=3 gives a period of 4 cycles and N=11 a period of 12, and an odd period has a high phase one cycle shorter than its low phase.
- R3: N=0 is treated as N=1, which gives a period of 2 reference cycles.
- R4: The value of `div_n` sampled on the last reference edge of a period sets the length of the next period. Changes of `div_n` at any other edge leave the running period unchanged.
- R5: Suspend is synchronised in two reference cycles. Once it is seen with `keep_fast` low, the machine counts `DELAY_CYC` reference cycles in `ST_ARMED` and then enters `ST_LAZY`, which hands `clk_out` to `slow_clk`. Until that edge `clk_out` keeps following the divided clock.
- R6: A suspend pulse that ends before the delay expires returns the machine to `ST_RUN`, and `clk_out` never leaves the divided clock.
- R7: While `keep_fast` is high the machine never enters `ST_LAZY`. Setting `keep_fast` during `ST_LAZY` returns the output to the divided clock.
- R8: When suspend drops in `ST_LAZY`, `clk_out` returns to the divided clock. The divider keeps running throughout the slow phase, so its phase is not reset by the fallback.
- R9: `clk_out` has no pulse or gap shorter than one reference cycle. The two sources are never enabled together, and the fast enable changes only while the divided clock is low.
- R10: A handover in either direction is complete within 3 slow-clock periods plus 12 reference cycles of the state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast reference clock. |
| slow_clk | input | 1 | Slow low-power clock, asynchronous to `ref_clk`. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| suspend | input | 1 | Suspend request, asynchronous. |
| keep_fast | input | 1 | When high, blocks the fallback to the slow clock (synchronous to `ref_clk`). |
| div_n | input | DIV_W | Division factor N (synchronous to `ref_clk`). |
| clk_out | output | 1 | Programmed clock output. |

## Verification
The mutual-exclusion and handover assertions assume that `suspend` and `keep_fast` hold each level long enough for a handover to finish before the selection reverses. A request that flips back during a half-finished handover could leave stale synchroniser values on the slow side. The stimulus therefore keeps every suspend and `keep_fast` phase longer than the handover bound, or short enough that the machine never leaves `ST_ARMED`. It also assumes that `div_n` and `keep_fast` change only just after reference edges, and that slow-clock edges never coincide with reference edges. The bench places its slow-clock edges at an offset that a reference edge never reaches.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARMED = 2'd1,
        ST_LAZY  = 2'd2
    } susp_state_t;

endpackage

// File: rtl/clkout_sync.sv
module clkout_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= {STAGES{RST_VAL}};
        end else begin
            shift_q <= {shift_q[STAGES-2:0], d};
        end
    end

    assign q = shift_q[STAGES-1];

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_n,
    output logic             div_clk
);

    localparam int CNT_W = DIV_W + 1;
    localparam logic [CNT_W-1:0] PER_MAX = CNT_W'(2 ** DIV_W);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] hi_q;
    logic             div_q;
    logic [DIV_W-1:0] n_eff;
    logic [CNT_W-1:0] per_in;
    logic [CNT_W-1:0] cnt_inc;
    logic             at_end;

    // R3: a zero factor is clamped to one.
    assign n_eff   = (div_n == '0) ? DIV_W'(1) : div_n;
    assign per_in  = CNT_W'(n_eff) + ONE;
    assign cnt_inc = cnt_q + ONE;
    assign at_end  = (cnt_q == per_q - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= PER_MAX;
            cnt_q <= PER_MAX - ONE;
            hi_q  <= PER_MAX >> 1;
            div_q <= 1'b0;
        end else if (at_end) begin
            // R4: the ratio is latched only here, after the low phase.
            cnt_q <= '0;
            per_q <= per_in;
            hi_q  <= per_in >> 1;
            div_q <= 1'b1;
        end else begin
            cnt_q <= cnt_inc;
            div_q <= (cnt_inc < hi_q);
        end
    end

    assign div_clk = div_q;

    assert_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_q) |-> (cnt_q == '0));

    assert_len_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != per_q - ONE) |=> $stable(per_q));

endmodule

// File: rtl/clkout_susp_fsm.sv
module clkout_susp_fsm
    import clkout_pkg::*;
#(
    parameter int DELAY_CYC = 48000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic susp_s,
    input  logic keep_fast,
    output logic want_slow
);

    localparam int DLY_W = $clog2(DELAY_CYC + 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_CYC - 1);

    susp_state_t      state_q;
    susp_state_t      state_d;
    logic [DLY_W-1:0] dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else if (state_q != ST_ARMED) begin
            dly_q <= '0;
        end else begin
            dly_q <= dly_q + DLY_W'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (susp_s && !keep_fast) state_d = ST_ARMED;      // arm
            end
            ST_ARMED: begin
                if (!susp_s || keep_fast) state_d = ST_RUN;         // abort
                else if (dly_q == DLY_LAST) state_d = ST_LAZY;      // expire
            end
            ST_LAZY: begin
                if (!susp_s || keep_fast) state_d = ST_RUN;         // wake
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        want_slow = (state_q == ST_LAZY);
    end

    assert_delay_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ARMED && state_q == ST_LAZY) |-> ($past(dly_q) == DLY_LAST));

    assert_keep_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        keep_fast |=> (state_q != ST_LAZY));

endmodule

// File: rtl/clkout_gmux.sv
module clkout_gmux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic slow_clk,
    input  logic rst_n,
    input  logic div_clk,
    input  logic want_slow,
    output logic clk_out
);

    logic slow_en_rs;
    logic fast_arm_q;
    logic fast_en_q;
    logic want_slow_ss;
    logic fast_en_ss;
    logic slow_en_q;

    // Fast side: the slow enable is brought into the reference domain.
    clkout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_slow_to_ref (
        .clk(ref_clk), .rst_n(rst_n), .d(slow_en_q), .q(slow_en_rs)
    );

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) fast_arm_q <= 1'b1;
        else        fast_arm_q <= !want_slow && !slow_en_rs;
    end

    // The enable moves on the falling edge and only while the divided clock is low.
    always_ff @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n)        fast_en_q <= 1'b1;
        else if (!div_clk) fast_en_q <= fast_arm_q;
    end

    // Slow side: the request and the fast enable are brought into the slow domain.
    clkout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_to_slow (
        .clk(slow_clk), .rst_n(rst_n), .d(want_slow), .q(want_slow_ss)
    );

    clkout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_fast_to_slow (
        .clk(slow_clk), .rst_n(rst_n), .d(fast_en_q), .q(fast_en_ss)
    );

    always_ff @(negedge slow_clk or negedge rst_n) begin
        if (!rst_n) slow_en_q <= 1'b0;
        else        slow_en_q <= want_slow_ss && !fast_en_ss;
    end

    assign clk_out = (div_clk & fast_en_q) | (slow_clk & slow_en_q);

    assert_exclusive_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(fast_en_q && slow_en_q));

    assert_fast_low_switch_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !$stable(fast_en_q) |-> !div_clk);

    assert_slow_after_fast_R9: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $rose(slow_en_q) |-> !fast_en_q);

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen #(
    parameter int DIV_W       = 4,
    parameter int DELAY_CYC   = 48000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic             suspend,
    input  logic             keep_fast,
    input  logic [DIV_W-1:0] div_n,
    output logic             clk_out
);

    logic div_clk;
    logic susp_s;
    logic want_slow;

    clkout_divider #(.DIV_W(DIV_W)) u_div (
        .clk(ref_clk), .rst_n(rst_n), .div_n(div_n), .div_clk(div_clk)
    );

    clkout_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_susp_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(suspend), .q(susp_s)
    );

    clkout_susp_fsm #(.DELAY_CYC(DELAY_CYC)) u_fsm (
        .clk(ref_clk), .rst_n(rst_n), .susp_s(susp_s),
        .keep_fast(keep_fast), .want_slow(want_slow)
    );

    clkout_gmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
        .ref_clk(ref_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .div_clk(div_clk), .want_slow(want_slow), .clk_out(clk_out)
    );

endmodule

// File: tb/clkout_gen_test.sv
`timescale 1ns/1ps
module clkout_gen_test;

    localparam int D      = 50;
    localparam int HAND_W = 3 * 20 + 12;   // R10 bound: 3 slow periods (20 ref cycles each) + 12

    logic       ref_clk = 1'b0;
    logic       slow_clk;
    logic       rst_n;
    logic       suspend;
    logic       keep_fast;
    logic [3:0] div_n;
    logic       clk_out;

    int n_chk = 0;
    int n_fail = 0;
    string cur = "R1";

    // Reference model state.
    int m_pos, m_len, m_hi, m_div;
    int m_s1, m_s2, m_st, m_dly, m_slow, m_hand;
    bit m_done;

    bit      mon_on = 1'b0;
    realtime last_t = 0.0;

    clkout_gen #(.DIV_W(4), .DELAY_CYC(D), .SYNC_STAGES(2)) uut (
        .ref_clk(ref_clk), .slow_clk(slow_clk), .rst_n(rst_n), .suspend(suspend),
        .keep_fast(keep_fast), .div_n(div_n), .clk_out(clk_out)
    );

    always #10 ref_clk = ~ref_clk;

    // Slow clock: 400 ns period; its edges fall 3 ns after a multiple of 20 ns, away from every reference edge.
    initial begin
        slow_clk = 1'b0;
        #3;
        forever #200 slow_clk = ~slow_clk;
    end

    task automatic check(input bit got, input bit exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: clk_out=%0b expected %0b", tag, $time, got, exp);
        end
    endtask

    task automatic model_edge();
        int seen;
        int prev;
        m_done = 1'b0;
        if (!rst_n) begin
            m_pos = 15; m_len = 16; m_hi = 8; m_div = 0;
            m_s1 = 0; m_s2 = 0; m_st = 0; m_dly = 0; m_slow = 0; m_hand = 0;
            return;
        end
        if (m_pos == m_len - 1) begin
            m_pos = 0;
            m_len = ((div_n == 0) ? 1 : int'(div_n)) + 1;
            m_hi  = m_len / 2;
            m_div = 1;
        end else begin
            m_pos++;
            m_div = (m_pos < m_hi) ? 1 : 0;
        end
        seen = m_s2;
        m_s2 = m_s1;
        m_s1 = suspend;
        prev = m_slow;
        case (m_st)
            0: if (seen != 0 && !keep_fast) begin m_st = 1; m_dly = 0; end
            1: begin
                if (seen == 0 || keep_fast) m_st = 0;
                else if (m_dly == D - 1) m_st = 2;
                else m_dly++;
            end
            default: if (seen == 0 || keep_fast) m_st = 0;
        endcase
        m_slow = (m_st == 2) ? 1 : 0;
        if (m_slow != prev) m_hand = HAND_W;
        else if (m_hand > 0) begin
            m_hand--;
            if (m_hand == 0) m_done = 1'b1;
        end
    endtask

    task automatic tick();
        string tag;
        @(posedge ref_clk);
        #5;
        model_edge();
        tag = m_done ? "R10" : cur;
        if (!rst_n) check(clk_out, 1'b0, "R1");
        else if (m_hand == 0) begin
            if (m_slow != 0) check(clk_out, slow_clk, tag);
            else             check(clk_out, m_div[0], tag);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // R9: no high or low interval shorter than one reference cycle.
    always @(clk_out) begin
        if (mon_on && rst_n) begin
            n_chk++;
            if ($realtime - last_t < 20.0) begin
                n_fail++;
                $display("FAIL R9 at %0t: interval %0t expected >= 20", $time, $realtime - last_t);
            end
        end
        last_t = $realtime;
    end

    initial begin
        #3_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; suspend = 1'b0; keep_fast = 1'b0; div_n = 4'd3;
        run(5);
        rst_n = 1'b1;
        mon_on = 1'b1;
        run(3);
        cur = "R2";
        run(37);
        div_n = 4'd11; run(48);
        div_n = 4'd6;  run(42);
        div_n = 4'd15; run(48);
        cur = "R4";
        for (int i = 0; i < 60; i++) begin
            tick();
            if (i % 5 == 2) div_n = 4'((i * 7) % 16);
        end
        cur = "R3";
        div_n = 4'd0; run(30);
        div_n = 4'd1; run(20);
        cur = "R6";
        div_n = 4'd4;
        suspend = 1'b1; run(D / 2);
        suspend = 1'b0; run(30);
        cur = "R7";
        keep_fast = 1'b1; suspend = 1'b1; run(3 * D);
        suspend = 1'b0; run(10);
        keep_fast = 1'b0; run(5);
        cur = "R5";
        div_n = 4'd5;
        suspend = 1'b1; run(D + 2 + HAND_W + 80);
        cur = "R8";
        suspend = 1'b0; run(HAND_W + 60);
        cur = "R7";
        suspend = 1'b1; run(D + 2 + HAND_W + 20);
        keep_fast = 1'b1; run(HAND_W + 40);
        keep_fast = 1'b0; suspend = 1'b0; run(10);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule